// File: doc/BRIEF.md
# Zoned TLB Lookup Unit

This block is a small, fully associative address-translation cache. Every slot holds a page whose size is a power of two, a tag that ties it to one process (or to all of them), a real page base, a 4-bit zone selector and a read/write/execute permission set. A lookup presents an effective address, the current process tag, the kind of access and whether the requester runs in user mode. One cycle later the block answers with a hit flag, the real address, the permissions it grants and a fault code.

Each zone has a 2-bit protection code held in a 32-bit zone register that comes in on a port. That code can grant every access, defer to the slot's own permissions, or block user accesses outright. A zone block and a permission refusal also rewrite a 32-bit syndrome register. Slots are loaded one at a time through a write port. Walking page tables in memory is left to other logic.

Top module: `ztlb_lookup`

## Requirements
- R1: While `rst_n` is low at a rising edge, `rsp_valid` and `syndrome` go to zero and every slot becomes invalid, so a lookup after reset misses.
- R2: A slot whose valid bit is clear never matches. A write on `wr_en` takes effect for lookups presented from the next cycle on. A lookup presented in the same cycle as a write sees the slot's old contents.
- R3: A slot of size code `s` covers 1024·2^s bytes. It matches only when the address, with its low 10+s bits cleared, equals the stored page number.
- R4: A stored process tag of zero matches any `req_pid`. Any other stored tag must equal `req_pid`.
- R5: On a hit, `rsp_addr` takes its bits above the page offset from the stored real page and its offset bits from the request address.
- R6: When several slots match, the one with the lowest index gives the result.
- R7: A miss returns `rsp_hit`=0, `rsp_fault`=1, `rsp_addr`=0 and `rsp_perm`=0, and leaves `syndrome` unchanged.
- R8: The zone code of zone z is `zpr[31-2z:30-2z]`, so zone 0 is the top bit pair and zone 15 the bottom one.
- R9: Zone code 3 grants all three permissions (`rsp_perm`=3'b111) with fault code 0 in either privilege mode, even when the slot itself allows nothing.
- R10: Zone code 2 grants all three permissions in supervisor mode (`req_user`=0). In user mode it uses the slot's own permissions.
- R11: Zone code 0 in user mode returns fault code 3 with `rsp_perm`=0 and sets `syndrome` to exactly bit 22. In supervisor mode it uses the slot's own permissions.
- R12: When the slot's own permissions decide (code 1, or the fallbacks of R10 and R11), `rsp_perm` equals them. Permission bits are bit 2 read, bit 1 write, bit 0 execute. Access codes are 0 fetch (needs execute), 1 load (needs read) and 2 store (needs write); code 3 is treated as a load. A refused access returns fault code 2 and clears `syndrome` to zero. A granted access returns fault code 0.
- R13: Every request with `req_valid` high produces exactly one response, with `rsp_valid` high, on the next rising edge. Responses come back in request order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write one slot this cycle |
| wr_idx | input | 3 | Slot to write |
| wr_valid | input | 1 | Valid bit to store |
| wr_size | input | 3 | Page size code (1024·2^code bytes) |
| wr_epn | input | 32 | Effective page number, offset bits zero |
| wr_rpn | input | 32 | Real page base |
| wr_pid | input | 8 | Process tag, zero = global |
| wr_zone | input | 4 | Zone selector |
| wr_perm | input | 3 | Permissions {read, write, execute} |
| zpr | input | 32 | Zone protection codes, 2 bits per zone |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Effective address |
| req_pid | input | 8 | Current process tag |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A slot matched |
| rsp_addr | output | 32 | Real address, zero on a miss |
| rsp_perm | output | 3 | Granted permissions {read, write, execute} |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 permission, 3 zone |
| syndrome | output | 32 | Syndrome register |

## Verification
A corrupted slot (wrong mask, tag or valid bit) shows up on the very next response as a wrong hit flag or a wrong real address. A wrong priority choice among overlapping slots shows up as the permissions or address of the wrong slot. A mistaken zone-code bit position shows up as a wrong fault code in the same response. Any error in the syndrome register stays visible until the next zone or permission fault, so checking it after a run of misses shows whether a stale value was carried or lost.

// File: rtl/ztlb_pkg.sv
// Shared types and helpers for the zoned TLB lookup unit.
// Assumes permission vectors are {read, write, execute}.
package ztlb_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_MISS = 2'd1,
        FLT_PROT = 2'd2,
        FLT_ZONE = 2'd3
    } fault_e;

    localparam int PERM_W = 3;
    localparam int PRM_R  = 2;
    localparam int PRM_W  = 1;
    localparam int PRM_X  = 0;

    // True when permission set p allows access kind acc (unused code acts as load).
    function automatic logic perm_allows(input logic [PERM_W-1:0] p, input logic [1:0] acc);
        case (acc)
            ACC_FETCH: return p[PRM_X];
            ACC_STORE: return p[PRM_W];
            default:   return p[PRM_R];
        endcase
    endfunction

endpackage

// File: rtl/ztlb_entry_array.sv
// Slot storage and associative match for the zoned TLB.
// Each slot compares the request under its own page mask and tag; the
// lowest-numbered matching slot drives the selected outputs.
// Assumes stored page numbers carry zero offset bits.
module ztlb_entry_array #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int PID_W   = 8,
    parameter int SZ_W    = 3,
    parameter int ZSEL_W  = 4,
    parameter int BASE_LG = 10,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic                        wr_valid,
    input  logic [SZ_W-1:0]             wr_size,
    input  logic [ADDR_W-1:0]           wr_epn,
    input  logic [ADDR_W-1:0]           wr_rpn,
    input  logic [PID_W-1:0]            wr_pid,
    input  logic [ZSEL_W-1:0]           wr_zone,
    input  logic [ztlb_pkg::PERM_W-1:0] wr_perm,
    input  logic [ADDR_W-1:0]           lk_addr,
    input  logic [PID_W-1:0]            lk_pid,
    output logic                        hit,
    output logic [ADDR_W-1:0]           raddr,
    output logic [ZSEL_W-1:0]           zone,
    output logic [ztlb_pkg::PERM_W-1:0] perm
);
    import ztlb_pkg::*;

    logic [ENTRIES-1:0]  ent_v;
    logic [SZ_W-1:0]     ent_sz   [ENTRIES];
    logic [ADDR_W-1:0]   ent_epn  [ENTRIES];
    logic [ADDR_W-1:0]   ent_rpn  [ENTRIES];
    logic [PID_W-1:0]    ent_pid  [ENTRIES];
    logic [ZSEL_W-1:0]   ent_zone [ENTRIES];
    logic [PERM_W-1:0]   ent_perm [ENTRIES];

    logic [ADDR_W-1:0]   pg_mask  [ENTRIES];
    logic [ENTRIES-1:0]  match;
    logic [ENTRIES-1:0]  grant;
    logic                taken;

    // Slot storage: clear on reset, overwrite one slot per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_v[i]    <= 1'b0;
                ent_sz[i]   <= '0;
                ent_epn[i]  <= '0;
                ent_rpn[i]  <= '0;
                ent_pid[i]  <= '0;
                ent_zone[i] <= '0;
                ent_perm[i] <= '0;
            end
        end else if (wr_en && (int'(wr_idx) < ENTRIES)) begin
            ent_v[wr_idx]    <= wr_valid;
            ent_sz[wr_idx]   <= wr_size;
            ent_epn[wr_idx]  <= wr_epn;
            ent_rpn[wr_idx]  <= wr_rpn;
            ent_pid[wr_idx]  <= wr_pid;
            ent_zone[wr_idx] <= wr_zone;
            ent_perm[wr_idx] <= wr_perm;
        end
    end

    // Per-slot page mask and match.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign pg_mask[g] = {ADDR_W{1'b1}} << (BASE_LG + int'(ent_sz[g]));
        assign match[g]   = ent_v[g]
                          && ((lk_addr & pg_mask[g]) == ent_epn[g])
                          && ((ent_pid[g] == '0) || (ent_pid[g] == lk_pid));
    end

    // Lowest-index priority pick among matching slots.
    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    // Route the chosen slot's translation and attributes.
    always_comb begin
        raddr = '0;
        zone  = '0;
        perm  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (grant[i]) begin
                raddr = (ent_rpn[i] & pg_mask[i]) | (lk_addr & ~pg_mask[i]);
                zone  = ent_zone[i];
                perm  = ent_perm[i];
            end
        end
    end

    assign hit = taken;

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2
    grant_valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~ent_v) == '0);

endmodule

// File: rtl/ztlb_zone_check.sv
// Zone protection resolver: turns the zone code of the chosen slot, the
// privilege level and the access kind into granted permissions and a fault.
// Assumes zone 0 owns the most significant code pair of zpr.
module ztlb_zone_check #(
    parameter int ZSEL_W = 4,
    parameter int ZPR_W  = 2 * (1 << ZSEL_W)
) (
    input  logic [ZPR_W-1:0]            zpr,
    input  logic [ZSEL_W-1:0]           zone,
    input  logic                        user,
    input  logic [1:0]                  acc,
    input  logic [ztlb_pkg::PERM_W-1:0] ent_perm,
    output logic [ztlb_pkg::PERM_W-1:0] perm,
    output ztlb_pkg::fault_e            fault
);
    import ztlb_pkg::*;

    logic [1:0] code;
    logic       use_entry;

    // Pick the zone code, then decide between forced grant, block or slot rights.
    always_comb begin
        code      = zpr[(ZPR_W - 2) - 2 * int'(zone) +: 2];
        use_entry = 1'b0;
        perm      = '0;
        fault     = FLT_NONE;
        case (code)
            2'd3: perm = '1;
            2'd2: if (user) use_entry = 1'b1; else perm = '1;
            2'd1: use_entry = 1'b1;
            default: if (user) fault = FLT_ZONE; else use_entry = 1'b1;
        endcase
        if (use_entry) begin
            perm = ent_perm;
            if (!perm_allows(ent_perm, acc)) fault = FLT_PROT;
        end
    end

endmodule

// File: rtl/ztlb_lookup.sv
// Zoned TLB lookup unit, top level.
// One-cycle lookup: slot match and zone resolution are combinational, the
// response and the syndrome register are captured on the next rising edge.
// Assumes a synchronous active-low reset and one request per cycle at most.
module ztlb_lookup #(
    parameter int ENTRIES       = 8,
    parameter int ADDR_W        = 32,
    parameter int PID_W         = 8,
    parameter int SZ_W          = 3,
    parameter int ZSEL_W        = 4,
    parameter int BASE_LG       = 10,
    parameter int SYND_W        = 32,
    parameter int SYND_ZONE_BIT = 22,
    parameter int IDX_W         = $clog2(ENTRIES),
    parameter int ZPR_W         = 2 * (1 << ZSEL_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_valid,
    input  logic [SZ_W-1:0]     wr_size,
    input  logic [ADDR_W-1:0]   wr_epn,
    input  logic [ADDR_W-1:0]   wr_rpn,
    input  logic [PID_W-1:0]    wr_pid,
    input  logic [ZSEL_W-1:0]   wr_zone,
    input  logic [2:0]          wr_perm,
    input  logic [ZPR_W-1:0]    zpr,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [PID_W-1:0]    req_pid,
    input  logic [1:0]          req_acc,
    input  logic                req_user,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [ADDR_W-1:0]   rsp_addr,
    output logic [2:0]          rsp_perm,
    output logic [1:0]          rsp_fault,
    output logic [SYND_W-1:0]   syndrome
);
    import ztlb_pkg::*;

    localparam logic [SYND_W-1:0] SYND_ZONE = SYND_W'(1) << SYND_ZONE_BIT;

    logic                 a_hit;
    logic [ADDR_W-1:0]    a_raddr;
    logic [ZSEL_W-1:0]    a_zone;
    logic [PERM_W-1:0]    a_perm;
    logic [PERM_W-1:0]    z_perm;
    fault_e               z_fault;

    ztlb_entry_array #(
        .ENTRIES (ENTRIES), .ADDR_W (ADDR_W), .PID_W (PID_W),
        .SZ_W (SZ_W), .ZSEL_W (ZSEL_W), .BASE_LG (BASE_LG), .IDX_W (IDX_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_valid (wr_valid),
        .wr_size  (wr_size),
        .wr_epn   (wr_epn),
        .wr_rpn   (wr_rpn),
        .wr_pid   (wr_pid),
        .wr_zone  (wr_zone),
        .wr_perm  (wr_perm),
        .lk_addr  (req_addr),
        .lk_pid   (req_pid),
        .hit      (a_hit),
        .raddr    (a_raddr),
        .zone     (a_zone),
        .perm     (a_perm)
    );

    ztlb_zone_check #(
        .ZSEL_W (ZSEL_W), .ZPR_W (ZPR_W)
    ) u_zone (
        .zpr      (zpr),
        .zone     (a_zone),
        .user     (req_user),
        .acc      (req_acc),
        .ent_perm (a_perm),
        .perm     (z_perm),
        .fault    (z_fault)
    );

    // Response register: capture translation result for each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_addr  <= '0;
            rsp_perm  <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit   <= a_hit;
                rsp_addr  <= a_hit ? a_raddr : '0;
                rsp_perm  <= a_hit ? z_perm  : '0;
                rsp_fault <= a_hit ? z_fault : FLT_MISS;
            end
        end
    end

    // Syndrome register: set on zone fault, cleared on permission fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syndrome <= '0;
        end else if (req_valid && a_hit) begin
            if (z_fault == FLT_ZONE)      syndrome <= SYND_ZONE;
            else if (z_fault == FLT_PROT) syndrome <= '0;
        end
    end

    // R7
    miss_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_MISS) |-> (!rsp_hit && rsp_addr == '0 && rsp_perm == '0));

    // R7
    miss_keeps_synd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_MISS) |-> (syndrome == $past(syndrome)));

    // R11
    zone_fault_synd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_ZONE) |-> (syndrome == SYND_ZONE && rsp_perm == '0));

    // R12
    prot_fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_PROT) |-> (syndrome == '0));

    // R13
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9
    clean_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE) |-> rsp_hit);

endmodule

// File: tb/sim_ztlb_lookup.sv
`timescale 1ns/1ps
module sim_ztlb_lookup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_size = '0;
    logic [31:0] wr_epn = '0;
    logic [31:0] wr_rpn = '0;
    logic [7:0]  wr_pid = '0;
    logic [3:0]  wr_zone = '0;
    logic [2:0]  wr_perm = '0;
    logic [31:0] zpr = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_pid = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_addr;
    logic [2:0]  rsp_perm;
    logic [1:0]  rsp_fault;
    logic [31:0] syndrome;

    always #2.5 clk = ~clk;

    ztlb_lookup u0 (
        .clk (clk), .rst_n (rst_n),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_valid (wr_valid), .wr_size (wr_size),
        .wr_epn (wr_epn), .wr_rpn (wr_rpn), .wr_pid (wr_pid), .wr_zone (wr_zone),
        .wr_perm (wr_perm), .zpr (zpr),
        .req_valid (req_valid), .req_addr (req_addr), .req_pid (req_pid),
        .req_acc (req_acc), .req_user (req_user),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_addr (rsp_addr),
        .rsp_perm (rsp_perm), .rsp_fault (rsp_fault), .syndrome (syndrome)
    );

    localparam logic [1:0] FETCH = 2'd0, LOAD = 2'd1, STORE = 2'd2;

    typedef struct {
        logic        hit;
        logic [31:0] addr;
        logic [2:0]  perm;
        logic [1:0]  fault;
        logic [31:0] synd;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;

    // Reference slot contents kept by the bench
    logic        m_v    [8];
    logic [2:0]  m_sz   [8];
    logic [31:0] m_epn  [8];
    logic [31:0] m_rpn  [8];
    logic [7:0]  m_pid  [8];
    logic [3:0]  m_zone [8];
    logic [2:0]  m_perm [8];
    logic [31:0] m_synd = '0;

    function automatic logic allows(logic [2:0] p, logic [1:0] acc);
        if (acc == FETCH) return p[0];
        if (acc == STORE) return p[1];
        return p[2];
    endfunction

    // Expected response from the requirements, updating the expected syndrome
    function automatic exp_t predict(logic [31:0] a, logic [7:0] pid, logic [1:0] acc,
                                     logic user, string tag);
        exp_t e;
        int   sel = -1;
        logic [31:0] mask;
        logic [1:0]  code;
        logic        ent;
        e.tag = tag; e.hit = 0; e.addr = 0; e.perm = 0; e.fault = 2'd1;
        for (int i = 7; i >= 0; i--) begin
            mask = 32'hFFFF_FFFF << (10 + int'(m_sz[i]));
            if (m_v[i] && ((a & mask) == m_epn[i]) && (m_pid[i] == 0 || m_pid[i] == pid))
                sel = i;
        end
        if (sel >= 0) begin
            mask   = 32'hFFFF_FFFF << (10 + int'(m_sz[sel]));
            e.hit  = 1;
            e.addr = (m_rpn[sel] & mask) | (a & ~mask);
            code   = zpr[31 - 2*int'(m_zone[sel]) -: 2];
            ent    = 0;
            e.fault = 2'd0;
            if (code == 2'd3) e.perm = 3'b111;
            else if (code == 2'd2) begin if (user) ent = 1; else e.perm = 3'b111; end
            else if (code == 2'd1) ent = 1;
            else begin if (user) begin e.fault = 2'd3; m_synd = 32'h0040_0000; end else ent = 1; end
            if (ent) begin
                e.perm = m_perm[sel];
                if (!allows(m_perm[sel], acc)) begin e.fault = 2'd2; m_synd = 0; end
            end
        end
        e.synd = m_synd;
        return e;
    endfunction

    task automatic put_slot(int idx, logic v, logic [2:0] sz, logic [31:0] epn,
                            logic [31:0] rpn, logic [7:0] pid, logic [3:0] zn, logic [2:0] pm);
        wr_en = 1; wr_idx = 3'(idx); wr_valid = v; wr_size = sz; wr_epn = epn;
        wr_rpn = rpn; wr_pid = pid; wr_zone = zn; wr_perm = pm;
        m_v[idx] = v; m_sz[idx] = sz; m_epn[idx] = epn; m_rpn[idx] = rpn;
        m_pid[idx] = pid; m_zone[idx] = zn; m_perm[idx] = pm;
    endtask

    task automatic wr_slot(int idx, logic v, logic [2:0] sz, logic [31:0] epn,
                           logic [31:0] rpn, logic [7:0] pid, logic [3:0] zn, logic [2:0] pm);
        @(negedge clk);
        req_valid = 0;
        put_slot(idx, v, sz, epn, rpn, pid, zn, pm);
        @(negedge clk);
        wr_en = 0;
    endtask

    // Driver: present one lookup and push its expected response
    task automatic look(logic [31:0] a, logic [7:0] pid, logic [1:0] acc, logic user, string tag);
        @(negedge clk);
        wr_en = 0;
        req_valid = 1; req_addr = a; req_pid = pid; req_acc = acc; req_user = user;
        q.push_back(predict(a, pid, acc, user, tag));
    endtask

    // Lookup in the same cycle as a slot write: old contents expected (R2)
    task automatic look_wr(logic [31:0] a, int idx, logic [31:0] rpn);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_pid = 0; req_acc = LOAD; req_user = 0;
        q.push_back(predict(a, 0, LOAD, 0, "R2"));
        put_slot(idx, 1, 3'd0, a & 32'hFFFF_FC00, rpn, 8'd0, 4'd15, 3'b100);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        req_valid = 0; wr_en = 0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: pop and compare each response away from the clock edge
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            n_chk++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL R13: response with no request pending, actual valid=1 expected valid=0");
            end else begin
                e = q.pop_front();
                if (rsp_hit !== e.hit || rsp_addr !== e.addr || rsp_perm !== e.perm ||
                    rsp_fault !== e.fault || syndrome !== e.synd) begin
                    n_fail++;
                    $display("FAIL %s: actual hit=%0b addr=%h perm=%b fault=%0d synd=%h expected hit=%0b addr=%h perm=%b fault=%0d synd=%h",
                             e.tag, rsp_hit, rsp_addr, rsp_perm, rsp_fault, syndrome,
                             e.hit, e.addr, e.perm, e.fault, e.synd);
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_v[i] = 0; m_sz[i] = 0; m_epn[i] = 0; m_rpn[i] = 0;
            m_pid[i] = 0; m_zone[i] = 0; m_perm[i] = 0;
        end
        // zone codes: zone 0 -> 0, zone 2 -> 2, zone 15 -> 3, all others -> 1 (R8)
        for (int z = 0; z < 16; z++) begin
            zpr[31 - 2*z -: 2] = (z == 0) ? 2'd0 : (z == 2) ? 2'd2 : (z == 15) ? 2'd3 : 2'd1;
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (rsp_valid !== 1'b0 || syndrome !== 32'h0) begin
            n_fail++;
            $display("FAIL R1: actual valid=%0b synd=%h expected valid=0 synd=0", rsp_valid, syndrome);
        end
        rst_n = 1;
        look(32'h0001_0000, 8'd0, LOAD, 0, "R1");

        wr_slot(0, 1, 3'd2, 32'h0001_0000, 32'h8004_0000, 8'd5, 4'd1, 3'b110);
        wr_slot(1, 1, 3'd0, 32'h0002_0400, 32'h0003_0000, 8'd0, 4'd2, 3'b100);
        wr_slot(2, 1, 3'd1, 32'h0005_0000, 32'h00A0_0800, 8'd7, 4'd0, 3'b111);
        wr_slot(3, 1, 3'd4, 32'h0006_0000, 32'h1234_5678, 8'd0, 4'd15, 3'b000);
        wr_slot(4, 1, 3'd2, 32'h0001_0000, 32'h9000_0000, 8'd0, 4'd1, 3'b111);
        wr_slot(5, 0, 3'd2, 32'h0007_0000, 32'h0000_0000, 8'd0, 4'd15, 3'b111);

        look(32'h0001_0123, 8'd5, LOAD,  1, "R13");
        look(32'h0001_0FFF, 8'd5, STORE, 0, "R5");
        look(32'h0001_1000, 8'd5, LOAD,  0, "R3");
        look(32'h0001_0010, 8'd6, LOAD,  1, "R4");
        look(32'h0001_0010, 8'd5, FETCH, 1, "R6");
        look(32'h0002_0455, 8'd9, LOAD,  1, "R10");
        look(32'h0002_0455, 8'd9, STORE, 1, "R10");
        look(32'h0002_0455, 8'd9, STORE, 0, "R10");
        look(32'h0005_0100, 8'd7, LOAD,  1, "R11");
        look(32'h0009_0000, 8'd7, LOAD,  0, "R7");
        look(32'h0005_07FF, 8'd7, FETCH, 0, "R8");
        look(32'h0005_0100, 8'd3, LOAD,  0, "R4");
        look(32'h0006_3ABC, 8'd2, STORE, 1, "R9");
        look(32'h0007_0010, 8'd0, LOAD,  0, "R2");
        look(32'h0001_0010, 8'd5, STORE, 1, "R12");
        look(32'h0001_0010, 8'd5, FETCH, 0, "R12");
        look(32'h0003_0000, 8'd1, FETCH, 1, "R7");

        wr_slot(0, 0, 3'd2, 32'h0001_0000, 32'h8004_0000, 8'd5, 4'd1, 3'b110);
        look(32'h0001_0010, 8'd5, FETCH, 1, "R2");

        look_wr(32'h000C_0040, 6, 32'h4400_0000);
        look(32'h000C_0040, 8'd0, LOAD, 0, "R2");

        for (int k = 0; k < 80; k++) begin
            logic [31:0] base;
            logic [7:0]  pid;
            case ($urandom % 7)
                0: base = 32'h0001_0000;
                1: base = 32'h0002_0400;
                2: base = 32'h0005_0000;
                3: base = 32'h0006_0000;
                4: base = 32'h0007_0000;
                5: base = 32'h000C_0000;
                default: base = 32'h0009_0000;
            endcase
            case ($urandom % 4)
                0: pid = 8'd0;
                1: pid = 8'd5;
                2: pid = 8'd6;
                default: pid = 8'd7;
            endcase
            look(base + ($urandom % 32'h1000), pid, 2'($urandom % 3), 1'($urandom % 2), "R5");
        end

        idle(4);
        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R13: actual %0d responses missing expected 0", q.size());
        end
        finish_run();
    end

endmodule